// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a set of configuration registers that exist once per hardware unit. A unit is named by a group number and an instance number inside that group. Software reaches the bank through one memory-mapped port that performs single-cycle reads and writes. A steering word selects the target group and instance and holds a broadcast flag. With the flag set, a write to a replicated register reaches every unit. With it clear, the write reaches only the steered unit. Reads always return the copy held by the steered unit, and the flag has no effect on them.

An input mask reports which units are present. A unit that is fused off or power-gated has its mask bit low. An access steered to such a unit is terminated without any error: a read returns zero and a unicast write is lost. The stored value of an absent unit stays as it was, so it shows again once the unit returns. A lock register lets agents serialize their use of the steering word. A read of the lock acquires it and reports whether it was granted. A write of 1 frees it. A small window of ordinary single-copy registers sits beside the replicated window and does not use the steering word.

Top module: `repl_reg_bank`

## Requirements
- R1: After reset the steering word reads 32'h8000_0000 (broadcast, group 0, instance 0), the lock is free, and every replicated and plain register reads 0.
- R2: A write to the replicated window (word addresses 0x10 to 0x13) with the broadcast flag set stores the data in every present unit.
- R3: A write to the replicated window with the broadcast flag clear stores the data only in the unit numbered group*NINST+instance, and no other unit changes.
- R4: A read of the replicated window returns the steered unit's copy whether the broadcast flag is set or clear.
- R5: A read steered to an absent unit, or to a group or instance number outside the configured range, returns 0.
- R6: A unicast write steered to an absent or out-of-range unit changes no stored value. The unit's earlier value reads back after it becomes present again.
- R7: A broadcast write leaves absent units unchanged and updates all present ones. Presence is taken from the mask in the same cycle as the write.
- R8: A read of the lock word (address 0x01) returns 1 and takes the lock when it is free. It returns 0 and leaves the lock held when it is taken. Writing 1 with bit 0 frees the lock, and writing 0 has no effect.
- R9: The plain registers (word addresses 0x20 to 0x23) keep one copy each, whatever the steering word or presence mask.
- R10: The steering word (address 0x00) holds the instance number in bits 7:0, the group number in bits 15:8 and the broadcast flag in bit 31. It reads back exactly those fields, and the other bits read as 0.
- R11: Read data appears on the data output in the cycle after the read request. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW (8) | Word address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, registered |
| unit_present | input | NGRP*NINST (4) | Presence mask; bit g*NINST+i set when that unit is usable |

## Verification
Two events can fall in the same cycle: a broadcast write and a change of the presence mask. The bench lowers one unit's mask bit in exactly the cycle of a broadcast write and raises it again in the next cycle. It then steers reads to each unit. The gated unit must still show its old value, while its neighbours must show the new data. This shows that presence is judged in the cycle of the write and not a cycle late or early.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  localparam int SEL_INST_LSB = 0;
  localparam int SEL_GRP_LSB  = 8;
  localparam int SEL_MC_BIT   = 31;

  function automatic int unit_index(logic [7:0] grp, logic [7:0] inst, int ninst);
    return int'(grp) * ninst + int'(inst);
  endfunction

  function automatic logic [31:0] pack_sel(logic mc, logic [7:0] grp, logic [7:0] inst);
    logic [31:0] w;
    w = '0;
    w[SEL_MC_BIT] = mc;
    w[SEL_GRP_LSB +: 8] = grp;
    w[SEL_INST_LSB +: 8] = inst;
    return w;
  endfunction
endpackage

// File: rtl/steer_ctl.sv
module steer_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_we,
  input  logic       wr_mc,
  input  logic [7:0] wr_grp,
  input  logic [7:0] wr_inst,
  input  logic       sem_rd,
  input  logic       sem_wr,
  input  logic       sem_wbit,
  output logic       mcast,
  output logic [7:0] grp,
  output logic [7:0] inst,
  output logic       sem_held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcast <= 1'b1;
      grp   <= '0;
      inst  <= '0;
    end else if (sel_we) begin
      mcast <= wr_mc;
      grp   <= wr_grp;
      inst  <= wr_inst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sem_held <= 1'b0;
    else if (sem_rd)            sem_held <= 1'b1;
    else if (sem_wr && sem_wbit) sem_held <= 1'b0;
  end
endmodule

// File: rtl/repl_array.sv
module repl_array #(
  parameter int NUNIT = 4,
  parameter int NREPL = 4,
  parameter int DW    = 32,
  localparam int RIW  = (NREPL > 1) ? $clog2(NREPL) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUNIT-1:0]          wr_mask,
  input  logic [RIW-1:0]            idx,
  input  logic [DW-1:0]             wr_data,
  output logic [NUNIT-1:0][DW-1:0]  rd_data
);
  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    logic [DW-1:0] mem [NREPL];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < NREPL; r++) mem[r] <= '0;
      end else if (wr_mask[u]) begin
        mem[idx] <= wr_data;
      end
    end
    assign rd_data[u] = mem[idx];
  end
endmodule

// File: rtl/plain_regs.sv
module plain_regs #(
  parameter int NPLAIN = 4,
  parameter int DW     = 32,
  localparam int PIW   = (NPLAIN > 1) ? $clog2(NPLAIN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [PIW-1:0] idx,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data
);
  logic [DW-1:0] mem [NPLAIN];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NPLAIN; r++) mem[r] <= '0;
    end else if (we) begin
      mem[idx] <= wr_data;
    end
  end
  assign rd_data = mem[idx];
endmodule

// File: rtl/repl_reg_bank.sv
module repl_reg_bank #(
  parameter int NGRP       = 2,
  parameter int NINST      = 2,
  parameter int NREPL      = 4,
  parameter int NPLAIN     = 4,
  parameter int DW         = 32,
  parameter int AW         = 8,
  parameter int SEL_ADDR   = 'h00,
  parameter int SEM_ADDR   = 'h01,
  parameter int REP_BASE   = 'h10,
  parameter int PLAIN_BASE = 'h20,
  localparam int NUNIT     = NGRP * NINST,
  localparam int RIW       = (NREPL > 1) ? $clog2(NREPL) : 1,
  localparam int PIW       = (NPLAIN > 1) ? $clog2(NPLAIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NUNIT-1:0] unit_present
);
  import rrb_pkg::*;

  // address decode
  logic [AW-1:0] rep_off, plain_off;
  logic sel_hit, sem_hit, rep_hit, plain_hit;
  assign rep_off   = bus_addr - AW'(REP_BASE);
  assign plain_off = bus_addr - AW'(PLAIN_BASE);
  assign sel_hit   = bus_addr == AW'(SEL_ADDR);
  assign sem_hit   = bus_addr == AW'(SEM_ADDR);
  assign rep_hit   = rep_off < AW'(NREPL);
  assign plain_hit = plain_off < AW'(NPLAIN);

  // named access events
  logic rd_req, wr_req, rep_wr, rep_rd, sem_rd, sem_grant, sem_release;
  assign rd_req      = bus_en && !bus_we;
  assign wr_req      = bus_en && bus_we;
  assign rep_wr      = wr_req && rep_hit;
  assign rep_rd      = rd_req && rep_hit;
  assign sem_rd      = rd_req && sem_hit;

  // steering state
  logic       sel_mcast, sem_held;
  logic [7:0] sel_grp, sel_inst;
  assign sem_grant   = sem_rd && !sem_held;
  assign sem_release = wr_req && sem_hit && bus_wdata[0];

  steer_ctl u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (wr_req && sel_hit),
    .wr_mc    (bus_wdata[SEL_MC_BIT]),
    .wr_grp   (bus_wdata[SEL_GRP_LSB +: 8]),
    .wr_inst  (bus_wdata[SEL_INST_LSB +: 8]),
    .sem_rd   (sem_grant),
    .sem_wr   (wr_req && sem_hit),
    .sem_wbit (bus_wdata[0]),
    .mcast    (sel_mcast),
    .grp      (sel_grp),
    .inst     (sel_inst),
    .sem_held (sem_held)
  );

  // target unit resolution
  logic             in_range, steer_live;
  int               tgt_idx;
  logic [NUNIT-1:0] ucast_mask, wr_unit_mask;
  assign in_range = (32'(sel_grp) < NGRP) && (32'(sel_inst) < NINST);
  assign tgt_idx  = unit_index(sel_grp, sel_inst, NINST);

  for (genvar u = 0; u < NUNIT; u++) begin : g_tgt
    assign ucast_mask[u] = in_range && (tgt_idx == u);
  end

  assign steer_live   = |(ucast_mask & unit_present);
  assign wr_unit_mask = !rep_wr   ? '0 :
                        sel_mcast ? unit_present :
                                    (ucast_mask & unit_present);

  // storage
  logic [NUNIT-1:0][DW-1:0] unit_rd;
  logic [DW-1:0]            plain_rd;

  repl_array #(.NUNIT(NUNIT), .NREPL(NREPL), .DW(DW)) u_repl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (wr_unit_mask),
    .idx     (rep_off[RIW-1:0]),
    .wr_data (bus_wdata),
    .rd_data (unit_rd)
  );

  plain_regs #(.NPLAIN(NPLAIN), .DW(DW)) u_plain (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_req && plain_hit),
    .idx     (plain_off[PIW-1:0]),
    .wr_data (bus_wdata),
    .rd_data (plain_rd)
  );

  // read path
  logic [DW-1:0] rep_val, rd_mux;
  always_comb begin
    rep_val = '0;
    for (int u = 0; u < NUNIT; u++)
      if (ucast_mask[u] && unit_present[u]) rep_val = unit_rd[u];
  end

  always_comb begin
    if (sel_hit)        rd_mux = DW'(pack_sel(sel_mcast, sel_grp, sel_inst));
    else if (sem_hit)   rd_mux = DW'(!sem_held);
    else if (rep_hit)   rd_mux = rep_val;
    else if (plain_hit) rd_mux = plain_rd;
    else                rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/repl_bank_chk.sv
module repl_bank_chk #(
  parameter int NUNIT = 4,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rep_wr,
  input logic             rep_rd,
  input logic             sem_rd,
  input logic             sem_held,
  input logic             sel_mcast,
  input logic             steer_live,
  input logic [NUNIT-1:0] wr_unit_mask,
  input logic [NUNIT-1:0] unit_present,
  input logic [DW-1:0]    bus_rdata
);
  AST_MCAST_PRESENT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rep_wr && sel_mcast |-> wr_unit_mask == unit_present); // R7
  AST_UCAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_wr && !sel_mcast |-> $onehot0(wr_unit_mask)); // R3
  AST_DEAD_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rep_wr && !sel_mcast && !steer_live |-> wr_unit_mask == '0); // R6
  AST_DEAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rep_rd && !steer_live |=> bus_rdata == '0); // R5
  AST_SEM_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    sem_rd && !sem_held |=> sem_held && bus_rdata == DW'(1)); // R8
  AST_SEM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sem_rd && sem_held |=> sem_held && bus_rdata == '0); // R8
endmodule

bind repl_reg_bank repl_bank_chk #(.NUNIT(NUNIT), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rep_wr       (rep_wr),
  .rep_rd       (rep_rd),
  .sem_rd       (sem_rd),
  .sem_held     (sem_held),
  .sel_mcast    (sel_mcast),
  .steer_live   (steer_live),
  .wr_unit_mask (wr_unit_mask),
  .unit_present (unit_present),
  .bus_rdata    (bus_rdata)
);

// File: tb/tb_repl_reg_bank.sv
module tb_repl_reg_bank;
  localparam int CLK_NS = 20;
  localparam logic [7:0] A_SEL = 8'h00, A_SEM = 8'h01, A_REP = 8'h10, A_PLN = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0]  unit_present = 4'b1111;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  repl_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .unit_present(unit_present)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic steer(logic mc, logic [7:0] g, logic [7:0] i);
    wr(A_SEL, {mc, 15'd0, g, i});
  endtask

  task automatic rd_unit(logic mc, logic [7:0] g, logic [7:0] i, logic [7:0] r,
                         output logic [31:0] d);
    steer(mc, g, i);
    rd(A_REP + r, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_SEL, d);          check("R1 steering reset", d, 32'h8000_0000);
    rd(A_REP + 8'd3, d);   check("R1 replicated reset", d, 32'h0);
    rd(A_PLN + 8'd1, d);   check("R1 plain reset", d, 32'h0);
  endtask

  task automatic t_selector();
    logic [31:0] d;
    steer(1'b0, 8'hA5, 8'h3C);
    rd(A_SEL, d);          check("R10 fields readback", d, 32'h0000_A53C);
    wr(A_SEL, 32'h7FFF_0102);
    rd(A_SEL, d);          check("R10 spare bits zero", d, 32'h0000_0102);
  endtask

  task automatic t_sem();
    logic [31:0] d;
    rd(A_SEM, d);          check("R8 grant when free", d, 32'd1);
    rd(A_SEM, d);          check("R8 busy when held", d, 32'd0);
    wr(A_SEM, 32'd0);
    rd(A_SEM, d);          check("R8 write 0 keeps lock", d, 32'd0);
    wr(A_SEM, 32'd1);
    rd(A_SEM, d);          check("R8 release then grant", d, 32'd1);
    wr(A_SEM, 32'd1);
  endtask

  task automatic t_mcast();
    logic [31:0] d;
    steer(1'b1, 8'd0, 8'd0);
    wr(A_REP + 8'd1, 32'hAAAA_0001);
    for (int u = 0; u < 4; u++) begin
      rd_unit(u[0], 8'(u / 2), 8'(u % 2), 8'd1, d);
      check("R2 R4 broadcast seen by unit", d, 32'hAAAA_0001);
    end
  endtask

  task automatic t_ucast();
    logic [31:0] d;
    steer(1'b0, 8'd1, 8'd0);   // unit 2
    wr(A_REP + 8'd1, 32'hBBBB_0002);
    for (int u = 0; u < 4; u++) begin
      rd_unit(1'b1, 8'(u / 2), 8'(u % 2), 8'd1, d);
      check("R3 unicast target only", d, (u == 2) ? 32'hBBBB_0002 : 32'hAAAA_0001);
    end
  endtask

  task automatic t_absent();
    logic [31:0] d;
    unit_present = 4'b1011;
    rd_unit(1'b0, 8'd1, 8'd0, 8'd1, d);  check("R5 absent read zero", d, 32'h0);
    wr(A_REP + 8'd1, 32'hCCCC_0003);     // unicast to absent unit 2
    steer(1'b1, 8'd0, 8'd0);
    wr(A_REP + 8'd2, 32'hDDDD_0004);
    rd_unit(1'b0, 8'd5, 8'd0, 8'd1, d);  check("R5 out-of-range group zero", d, 32'h0);
    wr(A_REP + 8'd1, 32'hEEEE_0005);     // unicast out of range dropped
    unit_present = 4'b1111;
    rd_unit(1'b0, 8'd1, 8'd0, 8'd1, d);  check("R6 dropped unicast", d, 32'hBBBB_0002);
    rd_unit(1'b0, 8'd1, 8'd0, 8'd2, d);  check("R7 broadcast skipped absent", d, 32'h0);
    rd_unit(1'b0, 8'd0, 8'd0, 8'd2, d);  check("R7 broadcast hit present", d, 32'hDDDD_0004);
    rd_unit(1'b0, 8'd1, 8'd1, 8'd1, d);  check("R6 out-of-range write dropped", d, 32'hAAAA_0001);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    steer(1'b1, 8'd0, 8'd0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_REP + 8'd3; bus_wdata = 32'h1234_5678;
    unit_present = 4'b1101;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; unit_present = 4'b1111;
    rd_unit(1'b0, 8'd0, 8'd1, 8'd3, d);  check("R7 gated in write cycle", d, 32'h0);
    rd_unit(1'b0, 8'd1, 8'd1, 8'd3, d);  check("R7 neighbour written", d, 32'h1234_5678);
  endtask

  task automatic t_plain();
    logic [31:0] d;
    steer(1'b0, 8'd1, 8'd0);
    unit_present = 4'b0000;
    wr(A_PLN + 8'd2, 32'h5A5A_0006);
    steer(1'b0, 8'd0, 8'd1);
    rd(A_PLN + 8'd2, d);   check("R9 plain ignores steering", d, 32'h5A5A_0006);
    unit_present = 4'b1111;
    rd(A_PLN + 8'd2, d);   check("R9 plain ignores presence", d, 32'h5A5A_0006);
    rd(8'h7F, d);          check("R11 unmapped read zero", d, 32'h0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = A_PLN + 8'd2;
    @(posedge clk); #1;
    check("R11 data after request edge", bus_rdata, 32'h5A5A_0006);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_selector();
    t_sem();
    t_mcast();
    t_ucast();
    t_absent();
    t_same_cycle();
    t_plain();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule